// File: doc/BRIEF.md
# Pre-Bias Rectifier On-Time Ramp

This block decides when a synchronous buck converter may start switching and how long the low-side (rectifier) switch may conduct, for the case where the output capacitor already holds a charge at power-up. If the rectifier conducted for the full complementary interval at once, it would pull current back out of the charged output. The block prevents this in two steps. First, it keeps the PWM disabled until a comparator reports that the soft-start level has risen above the feedback level. Then it starts the rectifier with a narrow on-time and widens it on each switching cycle until it matches the target complementary on-time.

The target is given in clock ticks and is normally the (1-D) share of the switching period. Once the limit reaches the target, the block raises a done flag and passes the target straight through, so the rectifier runs normally from then on. When no pre-bias is flagged, the ramp is skipped and the full limit is applied at once. A synchronous reset returns the block to the hold-off state.

Top module: `prebias_ramp`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `pwm_en` = 0, `ls_on_lim` = 0 and `ramp_done` = 0 on the following cycle.
- R2: While the block is held off with `prebias` = 1 and `ss_above_fb` = 0, it stays held off (`pwm_en` = 0, `ls_on_lim` = 0) whatever `cyc_stb` and `target_on` do.
- R3: From hold-off, a clock edge with `prebias` = 1 and `ss_above_fb` = 1 gives `pwm_en` = 1 and `ls_on_lim` = min(START_ON, `target_on`) one cycle later; START_ON defaults to 2.
- R4: During the ramp, each cycle with `cyc_stb` = 1 raises `ls_on_lim` by STEP (default 1), clamped to `target_on`. A cycle without a strobe leaves the limit unchanged.
- R5: When `ls_on_lim` reaches `target_on`, `ramp_done` rises. From then on, `ls_on_lim` equals the `target_on` of the previous cycle.
- R6: From hold-off with `prebias` = 0, the next cycle shows `pwm_en` = 1, `ramp_done` = 1 and `ls_on_lim` equal to `target_on`.
- R7: If `target_on` drops to or below the current limit during the ramp, the limit is set to `target_on` and `ramp_done` rises on the next cycle.
- R8: Once `pwm_en` is 1, it stays 1 until reset; later changes on `ss_above_fb` or `prebias` have no effect.
- R9: `ls_on_lim` never exceeds the `target_on` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | One-clock strobe per switching cycle |
| ss_above_fb | input | 1 | Comparator: soft-start level above feedback |
| prebias | input | 1 | Output found charged at start-up |
| target_on | input | TW | Full complementary on-time in clock ticks |
| pwm_en | output | 1 | Switching permitted |
| ls_on_lim | output | TW | Low-side on-time limit in clock ticks |
| ramp_done | output | 1 | Limit has reached the target |

## Verification
The main sequence runs a pre-biased start through hold-off, the comparator release, strobed and unstrobed cycles and the final clamp, and then moves the target up and down after done. This separates growth that is paced by strobes from growth that is paced by clocks, and separates tracking the target from holding the limit. Directed cases cover a start without pre-bias, a target below the narrow start width and a target that drops mid-ramp; these show whether the clamp is applied at entry, per step, or only at the end. Strobes sent during hold-off, and comparator or pre-bias changes after release, show whether those inputs are really ignored.

// File: rtl/prebias_ramp.sv
module prebias_ramp #(
  parameter int TW       = 8,
  parameter int START_ON = 2,
  parameter int STEP     = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_stb,
  input  logic          ss_above_fb,
  input  logic          prebias,
  input  logic [TW-1:0] target_on,
  output logic          pwm_en,
  output logic [TW-1:0] ls_on_lim,
  output logic          ramp_done
);
  localparam logic [TW-1:0] START_W = TW'(START_ON);
  localparam logic [TW:0]   STEP_W  = (TW+1)'(STEP);

  typedef enum logic [1:0] {S_HOLD, S_RAMP, S_DONE} st_t;
  st_t st;

  logic [TW-1:0] lim;
  logic [TW:0]   wide;
  logic [TW-1:0] bump;

  assign wide      = {1'b0, lim} + STEP_W;
  assign bump      = (wide > {1'b0, target_on}) ? target_on : wide[TW-1:0];
  assign pwm_en    = (st != S_HOLD);
  assign ramp_done = (st == S_DONE);
  assign ls_on_lim = lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_HOLD;
      lim <= '0;
    end else begin
      case (st)
        S_HOLD: begin
          if (!prebias) begin
            st  <= S_DONE;
            lim <= target_on;
          end else if (ss_above_fb) begin
            if (START_W >= target_on) begin
              st  <= S_DONE;
              lim <= target_on;
            end else begin
              st  <= S_RAMP;
              lim <= START_W;
            end
          end
        end
        S_RAMP: begin
          if (lim >= target_on) begin
            st  <= S_DONE;
            lim <= target_on;
          end else if (cyc_stb) begin
            lim <= bump;
            if (bump == target_on) st <= S_DONE;
          end
        end
        default: lim <= target_on;
      endcase
    end
  end
endmodule

module prebias_ramp_chk #(
  parameter int TW       = 8,
  parameter int START_ON = 2,
  parameter int STEP     = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cyc_stb,
  input logic          ss_above_fb,
  input logic          prebias,
  input logic [TW-1:0] target_on,
  input logic          pwm_en,
  input logic [TW-1:0] ls_on_lim,
  input logic          ramp_done
);
  localparam logic [TW-1:0] START_W = TW'(START_ON);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!pwm_en && ls_on_lim == '0 && !ramp_done)); // R1
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!pwm_en && prebias && !ss_above_fb) |=> (!pwm_en && ls_on_lim == '0)); // R2
  AST_START_NARROW: assert property (@(posedge clk) disable iff (rst)
    (!pwm_en && prebias && ss_above_fb) |=>
    (pwm_en && ls_on_lim == ((START_W < $past(target_on)) ? START_W : $past(target_on)))); // R3
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && !ramp_done && !cyc_stb && ls_on_lim < target_on) |=> ls_on_lim == $past(ls_on_lim)); // R4
  AST_DONE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    ramp_done |=> (ramp_done && ls_on_lim == $past(target_on))); // R5
  AST_NO_PREBIAS: assert property (@(posedge clk) disable iff (rst)
    (!pwm_en && !prebias) |=> (ramp_done && ls_on_lim == $past(target_on))); // R6
  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
    pwm_en |=> pwm_en); // R8
  AST_LIM_BOUND: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ls_on_lim <= $past(target_on)); // R9
  AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ramp_done |-> pwm_en); // R5
endmodule

bind prebias_ramp prebias_ramp_chk #(.TW(TW), .START_ON(START_ON), .STEP(STEP)) u_chk (.*);

// File: tb/prebias_ramp_tb.sv
`timescale 1ns/1ps
module prebias_ramp_tb;
  localparam int TW = 8;
  logic clk = 1'b0;
  logic rst, cyc_stb, ss_above_fb, prebias;
  logic [TW-1:0] target_on;
  logic pwm_en, ramp_done;
  logic [TW-1:0] ls_on_lim;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  prebias_ramp #(.TW(TW)) u_dut (.*);

  // {stb, ss, pb, target[8], exp_en, exp_lim[8], exp_done}
  localparam logic [20:0] VEC [9] = '{
    {1'b1,1'b0,1'b1,8'd6, 1'b0,8'd0,1'b0},   // R2 strobe while held
    {1'b0,1'b1,1'b1,8'd6, 1'b1,8'd2,1'b0},   // R3 narrow start
    {1'b1,1'b1,1'b1,8'd6, 1'b1,8'd3,1'b0},   // R4 step
    {1'b0,1'b0,1'b1,8'd6, 1'b1,8'd3,1'b0},   // R4 no strobe, R8 ss drop
    {1'b1,1'b0,1'b0,8'd6, 1'b1,8'd4,1'b0},   // R8 prebias drop
    {1'b1,1'b0,1'b0,8'd6, 1'b1,8'd5,1'b0},   // R4
    {1'b1,1'b0,1'b0,8'd6, 1'b1,8'd6,1'b1},   // R5 reach
    {1'b1,1'b0,1'b0,8'd9, 1'b1,8'd9,1'b1},   // R5 track up
    {1'b0,1'b0,1'b0,8'd3, 1'b1,8'd3,1'b1}    // R5 track down
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string rq, input logic en, input logic [TW-1:0] lim, input logic dn);
    n_chk++;
    if (pwm_en !== en || ls_on_lim !== lim || ramp_done !== dn) begin
      n_bad++;
      $display("FAIL %s: got en=%0b lim=%0d done=%0b, expected en=%0b lim=%0d done=%0b",
               rq, pwm_en, ls_on_lim, ramp_done, en, lim, dn);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cyc_stb = 0; ss_above_fb = 0; prebias = 1; target_on = 8'd6;
    step(); step(); rst = 1'b0;
    chk("R1", 1'b0, 8'd0, 1'b0);

    for (int i = 0; i < 9; i++) begin
      {cyc_stb, ss_above_fb, prebias, target_on} = VEC[i][20:10];
      step();
      chk($sformatf("R3/R4/R5/R8 vec%0d", i), VEC[i][9], VEC[i][8:1], VEC[i][0]);
    end

    // R1 reset mid-operation
    do_reset(); cyc_stb = 0; prebias = 1; ss_above_fb = 0;
    chk("R1", 1'b0, 8'd0, 1'b0);

    // R2 held across strobes and target changes
    for (int i = 0; i < 4; i++) begin
      cyc_stb = i[0]; target_on = 8'(20 + i); step();
      chk("R2", 1'b0, 8'd0, 1'b0);
    end

    // R6 no pre-bias
    cyc_stb = 0; prebias = 0; target_on = 8'd7; step();
    chk("R6", 1'b1, 8'd7, 1'b1);

    // R3 target below narrow start
    do_reset(); prebias = 1; ss_above_fb = 1; target_on = 8'd1; step();
    chk("R3", 1'b1, 8'd1, 1'b1);

    // R7 target drops mid-ramp
    do_reset(); prebias = 1; ss_above_fb = 1; target_on = 8'd10; step();
    chk("R3", 1'b1, 8'd2, 1'b0);
    ss_above_fb = 0; cyc_stb = 1; step();
    chk("R4", 1'b1, 8'd3, 1'b0);
    cyc_stb = 0; target_on = 8'd2; step();
    chk("R7", 1'b1, 8'd2, 1'b1);
    target_on = 8'd12; step();
    chk("R5", 1'b1, 8'd12, 1'b1);

    // R9 clamp on the final strobe step
    do_reset(); prebias = 1; ss_above_fb = 1; target_on = 8'd3; step();
    cyc_stb = 1; step();
    chk("R9", 1'b1, 8'd3, 1'b1);
    cyc_stb = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule